// File: doc/BRIEF.md
# Sleep-Gated NCO Waveform Core

This block is a numerically controlled oscillator. A 28-bit accumulator adds one of two frequency words on every enabled clock. One of two 12-bit phase offsets is added to the top of the accumulator. The resulting 12-bit phase either goes through a quarter-wave sine table or is folded into a linear triangle. Either way, a 10-bit offset-binary amplitude word drives an external DAC.

Two sleep controls sit in front of the datapath:

- **Clock-disable sleep** freezes the accumulator and both pipeline stages behind it, so the amplitude holds its value. The register banks stay writable during this sleep. Anything written while frozen shows up once the clock runs again.
- **DAC power-down** forces the output to mid-scale and drops `dac_enable`.

A select input decides what drives these controls. Either an asynchronous sleep pin drives the power-down, or two software bits drive both controls. The pin acts at once when raised. It is released only after two falling clock edges.

Top module: `nco_wave_core`

## Requirements
- R1: Synchronous active-low reset clears the accumulator, the phase stage and all four offset/frequency registers, and sets the amplitude stage to mid-scale 512. With no sleep active, amp_out reads 512 and dac_enable reads 1 right after reset.
- R2: On each enabled rising edge, the accumulator adds the frequency word picked by `freq_sel`, modulo 2^28. On that edge the phase stage loads accumulator bits [27:16] plus the offset picked by `phase_sel`, modulo 4096. The amplitude stage loads the waveform of the previous phase stage. A register write changes the accumulator at the next enabled edge and reaches amp_out one enabled edge after that stage.
- R3: When `pin_sw_sel` is 0 and `ctl_clk_off` is 1, the accumulator, phase stage and amplitude stage all hold their values on every edge.
- R4: Writes to either bank through `freq_we`/`phase_we` (bank chosen by `freq_idx`/`phase_idx`), and changes of `freq_sel`/`phase_sel`, are accepted while frozen. After release they reach amp_out with the latency of R2.
- R5: When `pin_sw_sel` is 1, raising `sleep_pin` powers the DAC down immediately, with no clock edge needed. After `sleep_pin` falls, the power-down persists until the second falling clock edge, and is gone after it.
- R6: When `pin_sw_sel` is 0, `ctl_dac_off` alone decides DAC power-down, independently of `ctl_clk_off`, and both may be set together. `sleep_pin` then has no effect. When `pin_sw_sel` is 1, both control bits have no effect.
- R7: While the DAC is powered down, amp_out is 512 and dac_enable is 0. Otherwise dac_enable is 1 and amp_out equals the amplitude stage.
- R8: With `wave_tri` 0, for phase p: q = p[11:10], i = p[9:0], j = (q[0] ? 1023-i : i), m = round(511·sin((j+0.5)·π/2048)). The amplitude is 512+m when q[1] is 0, and 511-m when q[1] is 1. So p=0 gives 512, p=1024 gives 1023, p=2048 gives 511 and p=3072 gives 0.
- R9: With `wave_tri` 1, t = p[11:1]. The amplitude is t[9:0] when t[10] is 0 and ~t[9:0] when it is 1. A full phase sweep therefore reaches 0 and 1023 once each per period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| freq_we | input | 1 | Write strobe for a frequency register |
| freq_idx | input | 1 | Frequency register written |
| freq_data | input | 28 | Frequency word to write |
| phase_we | input | 1 | Write strobe for a phase register |
| phase_idx | input | 1 | Phase register written |
| phase_data | input | 12 | Phase offset to write |
| freq_sel | input | 1 | Frequency register feeding the accumulator |
| phase_sel | input | 1 | Phase register added to the accumulator |
| wave_tri | input | 1 | 0 sine, 1 triangle |
| pin_sw_sel | input | 1 | 1 pin controls power-down, 0 software bits control both sleeps |
| sleep_pin | input | 1 | Asynchronous DAC power-down request |
| ctl_clk_off | input | 1 | Software clock-disable sleep |
| ctl_dac_off | input | 1 | Software DAC power-down |
| amp_out | output | 10 | Amplitude word, offset binary |
| dac_enable | output | 1 | High when the DAC is powered |

## Verification
The functions that collide are register writes and the clock-disable freeze: a write or a select change can land in the very cycle the accumulator is frozen, or in the cycle it is released. Random stimulus toggles `ctl_clk_off`, both write strobes and both selects independently on each cycle. A directed run also writes new words throughout a long freeze. A bench model that applies writes after reading the old register contents, and advances only on enabled edges, predicts every output sample. During the freeze the held amplitude is compared cycle by cycle, and after release the new words must appear at exactly the R2 latency.

// File: rtl/nco_pkg.sv
// Package: shared types for the sleep-gated NCO core.
// Assumes: nothing beyond IEEE 1800-2017.
package nco_pkg;

    // Waveform selection applied at the amplitude stage.
    typedef enum logic {
        WAVE_SINE = 1'b0,
        WAVE_TRI  = 1'b1
    } wave_e;

    // Qualified sleep state handed from the sleep controller to the datapath.
    typedef struct packed {
        logic clk_off;   // accumulator and pipeline frozen
        logic dac_down;  // DAC powered down, output forced mid-scale
    } sleep_state_t;

endpackage

// File: rtl/nco_sleep_ctl.sv
// Module: nco_sleep_ctl
// Resolves the pin and software sleep requests into one clock-freeze flag
// and one DAC power-down flag. The pin asserts asynchronously. Its release
// passes through a falling-edge synchroniser of SYNC_STAGES flops.
// Assumes: sleep_pin may change at any time; all other inputs are synchronous.
module nco_sleep_ctl #(
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sleep_pin,
    input  logic                  pin_sw_sel,
    input  logic                  ctl_clk_off,
    input  logic                  ctl_dac_off,
    output nco_pkg::sleep_state_t state
);

    logic [SYNC_STAGES-1:0] rel_sync;
    logic                   pin_hold;

    // Release synchroniser: set at once by the pin, drained on falling edges.
    always_ff @(negedge clk or posedge sleep_pin) begin
        if (sleep_pin) begin
            rel_sync <= '1;
        end else if (!rst_n) begin
            rel_sync <= '0;
        end else begin
            rel_sync <= {rel_sync[SYNC_STAGES-2:0], 1'b0};
        end
    end

    assign pin_hold = rel_sync[SYNC_STAGES-1];

    // Source selection between the pin and the software control bits.
    always_comb begin
        if (pin_sw_sel) begin
            state.clk_off  = 1'b0;
            state.dac_down = sleep_pin | pin_hold;
        end else begin
            state.clk_off  = ctl_clk_off;
            state.dac_down = ctl_dac_off;
        end
    end

endmodule

// File: rtl/nco_phase_acc.sv
// Module: nco_phase_acc
// Holds the frequency and phase register banks, the phase accumulator and
// the registered phase sum. The banks accept writes on every edge. The
// accumulator and phase stage advance only while run is high.
// Assumes: NREG is a power of two so every index selects a real register.
module nco_phase_acc #(
    parameter int ACC_W = 28,
    parameter int PH_W  = 12,
    parameter int NREG  = 2,
    localparam int SEL_W = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             freq_we,
    input  logic [SEL_W-1:0] freq_idx,
    input  logic [ACC_W-1:0] freq_data,
    input  logic             phase_we,
    input  logic [SEL_W-1:0] phase_idx,
    input  logic [PH_W-1:0]  phase_data,
    input  logic [SEL_W-1:0] freq_sel,
    input  logic [SEL_W-1:0] phase_sel,
    output logic [ACC_W-1:0] acc_q,
    output logic [PH_W-1:0]  phase_q
);

    logic [ACC_W-1:0] fw_bank [NREG];
    logic [PH_W-1:0]  po_bank [NREG];

    // Frequency bank: cleared by reset, written whenever the strobe is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int g = 0; g < NREG; g++) fw_bank[g] <= '0;
        end else if (freq_we) begin
            fw_bank[freq_idx] <= freq_data;
        end
    end

    // Phase bank: cleared by reset, written whenever the strobe is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int g = 0; g < NREG; g++) po_bank[g] <= '0;
        end else if (phase_we) begin
            po_bank[phase_idx] <= phase_data;
        end
    end

    // Accumulator: adds the selected tuning word on enabled edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (run) begin
            acc_q <= acc_q + fw_bank[freq_sel];
        end
    end

    // Phase stage: truncated accumulator plus the selected offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (run) begin
            phase_q <= acc_q[ACC_W-1 -: PH_W] + po_bank[phase_sel];
        end
    end

endmodule

// File: rtl/nco_wave_shaper.sv
// Module: nco_wave_shaper
// Maps the registered phase to a registered amplitude, either through a
// quarter-wave sine table computed at elaboration or through a linear fold.
// Assumes: PH_W = AMP_W + 2, so the table index is phase bits below the
// quadrant and the fold uses the top AMP_W+1 phase bits.
module nco_wave_shaper #(
    parameter int PH_W  = 12,
    parameter int AMP_W = 10,
    localparam int QBITS = PH_W - 2,
    localparam int QN    = 1 << QBITS,
    localparam int HALF  = 1 << (AMP_W - 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  nco_pkg::wave_e      mode,
    input  logic [PH_W-1:0]     phase_q,
    output logic [AMP_W-1:0]    amp_q
);

    localparam logic [AMP_W-1:0] MID = AMP_W'(HALF);

    // Quarter-wave magnitude for table entry k, sampled at bin centres.
    function automatic logic [AMP_W-2:0] qsin(input int k);
        real ang;
        int  v;
        ang = (real'(k) + 0.5) * 3.14159265358979 / (2.0 * real'(QN));
        v   = $rtoi(real'(HALF - 1) * $sin(ang) + 0.5);
        return v[AMP_W-2:0];
    endfunction

    logic [AMP_W-2:0] qtbl [QN];

    for (genvar k = 0; k < QN; k++) begin : g_qtbl
        assign qtbl[k] = qsin(k);
    end

    logic [1:0]       quad;
    logic [QBITS-1:0] qidx;
    logic [AMP_W-2:0] mag;
    logic [AMP_W-1:0] sine_amp;
    logic [AMP_W:0]   fold_in;
    logic [AMP_W-1:0] tri_amp;

    // Sine path: mirror the index in odd quadrants, negate in the lower half.
    always_comb begin
        quad     = phase_q[PH_W-1 -: 2];
        qidx     = quad[0] ? ~phase_q[QBITS-1:0] : phase_q[QBITS-1:0];
        mag      = qtbl[qidx];
        sine_amp = quad[1] ? (MID - 1'b1 - {1'b0, mag}) : (MID + {1'b0, mag});
    end

    // Triangle path: invert the lower bits during the falling half.
    always_comb begin
        fold_in = phase_q[PH_W-1 -: AMP_W+1];
        tri_amp = fold_in[AMP_W] ? ~fold_in[AMP_W-1:0] : fold_in[AMP_W-1:0];
    end

    // Amplitude stage: registers the chosen waveform on enabled edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            amp_q <= MID;
        end else if (run) begin
            amp_q <= (mode == nco_pkg::WAVE_TRI) ? tri_amp : sine_amp;
        end
    end

endmodule

// File: rtl/nco_wave_core.sv
// Module: nco_wave_core
// Top of the sleep-gated NCO: sleep qualification, phase accumulation and
// waveform shaping, with the DAC power-down applied at the output.
// Assumes: one clock domain; sleep_pin is the only asynchronous input.
module nco_wave_core #(
    parameter int ACC_W = 28,
    parameter int PH_W  = 12,
    parameter int AMP_W = 10,
    parameter int NREG  = 2,
    parameter int SYNC_STAGES = 2,
    localparam int SEL_W = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             freq_we,
    input  logic [SEL_W-1:0] freq_idx,
    input  logic [ACC_W-1:0] freq_data,
    input  logic             phase_we,
    input  logic [SEL_W-1:0] phase_idx,
    input  logic [PH_W-1:0]  phase_data,
    input  logic [SEL_W-1:0] freq_sel,
    input  logic [SEL_W-1:0] phase_sel,
    input  logic             wave_tri,
    input  logic             pin_sw_sel,
    input  logic             sleep_pin,
    input  logic             ctl_clk_off,
    input  logic             ctl_dac_off,
    output logic [AMP_W-1:0] amp_out,
    output logic             dac_enable
);

    localparam logic [AMP_W-1:0] MID = AMP_W'(1 << (AMP_W - 1));

    nco_pkg::sleep_state_t slp;
    logic                  run;
    logic [ACC_W-1:0]      acc_q;
    logic [PH_W-1:0]       phase_q;
    logic [AMP_W-1:0]      amp_q;

    nco_sleep_ctl #(.SYNC_STAGES(SYNC_STAGES)) u_sleep (
        .clk         (clk),
        .rst_n       (rst_n),
        .sleep_pin   (sleep_pin),
        .pin_sw_sel  (pin_sw_sel),
        .ctl_clk_off (ctl_clk_off),
        .ctl_dac_off (ctl_dac_off),
        .state       (slp)
    );

    assign run = !slp.clk_off;

    nco_phase_acc #(.ACC_W(ACC_W), .PH_W(PH_W), .NREG(NREG)) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .freq_we    (freq_we),
        .freq_idx   (freq_idx),
        .freq_data  (freq_data),
        .phase_we   (phase_we),
        .phase_idx  (phase_idx),
        .phase_data (phase_data),
        .freq_sel   (freq_sel),
        .phase_sel  (phase_sel),
        .acc_q      (acc_q),
        .phase_q    (phase_q)
    );

    nco_wave_shaper #(.PH_W(PH_W), .AMP_W(AMP_W)) u_shape (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .mode    (nco_pkg::wave_e'(wave_tri)),
        .phase_q (phase_q),
        .amp_q   (amp_q)
    );

    // Output stage: mid-scale and disable while the DAC is powered down.
    always_comb begin
        dac_enable = !slp.dac_down;
        amp_out    = slp.dac_down ? MID : amp_q;
    end

endmodule

// File: rtl/nco_wave_core_chk.sv
// Module: nco_wave_core_chk
// Property checker bound to nco_wave_core. It watches the ports and the
// accumulator and amplitude stages.
// Assumes: sampled on the rising clock edge, disabled during reset.
module nco_wave_core_chk #(
    parameter int ACC_W = 28,
    parameter int AMP_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pin_sw_sel,
    input logic             sleep_pin,
    input logic             ctl_clk_off,
    input logic             ctl_dac_off,
    input logic [AMP_W-1:0] amp_out,
    input logic             dac_enable,
    input logic [ACC_W-1:0] acc_q,
    input logic [AMP_W-1:0] amp_q
);

    localparam logic [AMP_W-1:0] MID = AMP_W'(1 << (AMP_W - 1));

    logic freeze_req;
    assign freeze_req = !pin_sw_sel && ctl_clk_off;

    assert_freeze_acc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        freeze_req |=> acc_q == $past(acc_q));

    assert_freeze_amp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        freeze_req |=> amp_q == $past(amp_q));

    assert_pin_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_sw_sel && sleep_pin) |-> !dac_enable);

    assert_soft_dac_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_sw_sel |-> (dac_enable == !ctl_dac_off));

    assert_mid_scale_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_enable |-> (amp_out == MID));

endmodule

bind nco_wave_core nco_wave_core_chk #(.ACC_W(ACC_W), .AMP_W(AMP_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_sw_sel  (pin_sw_sel),
    .sleep_pin   (sleep_pin),
    .ctl_clk_off (ctl_clk_off),
    .ctl_dac_off (ctl_dac_off),
    .amp_out     (amp_out),
    .dac_enable  (dac_enable),
    .acc_q       (acc_q),
    .amp_q       (amp_q)
);

// File: tb/nco_wave_core_test.sv
`timescale 1ns/1ps
module nco_wave_core_test;

    localparam int CLK_PERIOD = 10;
    localparam int ACC_W = 28;
    localparam int PH_W  = 12;
    localparam int AMP_W = 10;
    localparam int NREG  = 2;
    localparam int MID   = 512;
    localparam real PI   = 3.14159265358979;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             freq_we = 1'b0;
    logic [0:0]       freq_idx = '0;
    logic [ACC_W-1:0] freq_data = '0;
    logic             phase_we = 1'b0;
    logic [0:0]       phase_idx = '0;
    logic [PH_W-1:0]  phase_data = '0;
    logic [0:0]       freq_sel = '0;
    logic [0:0]       phase_sel = '0;
    logic             wave_tri = 1'b0;
    logic             pin_sw_sel = 1'b0;
    logic             sleep_pin = 1'b0;
    logic             ctl_clk_off = 1'b0;
    logic             ctl_dac_off = 1'b0;
    logic [AMP_W-1:0] amp_out;
    logic             dac_enable;

    nco_wave_core uut (
        .clk(clk), .rst_n(rst_n),
        .freq_we(freq_we), .freq_idx(freq_idx), .freq_data(freq_data),
        .phase_we(phase_we), .phase_idx(phase_idx), .phase_data(phase_data),
        .freq_sel(freq_sel), .phase_sel(phase_sel), .wave_tri(wave_tri),
        .pin_sw_sel(pin_sw_sel), .sleep_pin(sleep_pin),
        .ctl_clk_off(ctl_clk_off), .ctl_dac_off(ctl_dac_off),
        .amp_out(amp_out), .dac_enable(dac_enable)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;

    logic [ACC_W-1:0] m_acc;
    logic [PH_W-1:0]  m_ph;
    logic [AMP_W-1:0] m_amp;
    logic [ACC_W-1:0] m_fw [NREG];
    logic [PH_W-1:0]  m_po [NREG];

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [AMP_W-1:0] exp_sine(input logic [PH_W-1:0] p);
        int  i;
        int  j;
        int  m;
        real r;
        i = int'(p[9:0]);
        j = p[10] ? 1023 - i : i;
        r = 511.0 * $sin((real'(j) + 0.5) * PI / 2048.0);
        m = $rtoi(r + 0.5);
        return p[11] ? AMP_W'(511 - m) : AMP_W'(512 + m);
    endfunction

    function automatic logic [AMP_W-1:0] exp_tri(input logic [PH_W-1:0] p);
        int t;
        t = int'(p[11:1]);
        return (t >= 1024) ? AMP_W'(2047 - t) : AMP_W'(t);
    endfunction

    task automatic model_reset();
        m_acc = '0; m_ph = '0; m_amp = AMP_W'(MID);
        for (int g = 0; g < NREG; g++) begin
            m_fw[g] = '0;
            m_po[g] = '0;
        end
    endtask

    // Advance the model on one rising edge: read old state, then apply writes.
    task automatic model_edge();
        if (!(!pin_sw_sel && ctl_clk_off)) begin
            m_amp = wave_tri ? exp_tri(m_ph) : exp_sine(m_ph);
            m_ph  = m_acc[ACC_W-1 -: PH_W] + m_po[phase_sel];
            m_acc = m_acc + m_fw[freq_sel];
        end
        if (freq_we)  m_fw[freq_idx]  = freq_data;
        if (phase_we) m_po[phase_idx] = phase_data;
    endtask

    // One clock: model update at the edge, compare a quarter period later.
    task automatic step(input string req);
        logic down;
        @(posedge clk);
        model_edge();
        #(CLK_PERIOD/4);
        down = pin_sw_sel ? sleep_pin : ctl_dac_off;
        check(req, int'(amp_out), down ? MID : int'(m_amp));
        check(req, int'(dac_enable), down ? 0 : 1);
    endtask

    task automatic write_phase(input int idx, input int val, input string req);
        phase_we = 1'b1; phase_idx = 1'(idx); phase_data = PH_W'(val);
        step(req);
        phase_we = 1'b0;
    endtask

    task automatic write_freq(input int idx, input logic [ACC_W-1:0] val, input string req);
        freq_we = 1'b1; freq_idx = 1'(idx); freq_data = val;
        step(req);
        freq_we = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [AMP_W-1:0] held;
        int zero_runs;
        int peak_runs;
        int lo;
        int hi;
        int prev;
        int guard;
        void'($urandom(32'd7321));

        // R1: reset state
        repeat (3) @(posedge clk);
        model_reset();
        #(CLK_PERIOD/4);
        check("R1 reset amp", int'(amp_out), MID);
        check("R1 reset enable", int'(dac_enable), 1);
        rst_n = 1'b1;
        step("R1");
        check("R1 first sample", int'(amp_out), MID);

        // R8: sine quadrant points with a frozen accumulator (all words zero)
        write_phase(0, 1024, "R8");
        repeat (3) step("R8");
        check("R8 p=1024", int'(amp_out), 1023);
        write_phase(0, 2048, "R8");
        repeat (3) step("R8");
        check("R8 p=2048", int'(amp_out), 511);
        write_phase(0, 3072, "R8");
        repeat (3) step("R8");
        check("R8 p=3072", int'(amp_out), 0);

        // R9: triangle fold points
        wave_tri = 1'b1;
        write_phase(0, 1024, "R9");
        repeat (3) step("R9");
        check("R9 p=1024", int'(amp_out), 512);
        write_phase(0, 2048, "R9");
        repeat (3) step("R9");
        check("R9 p=2048", int'(amp_out), 1023);
        write_phase(0, 4095, "R9");
        repeat (3) step("R9");
        check("R9 p=4095", int'(amp_out), 0);

        // R3/R4: freeze with writes landing during the freeze
        wave_tri = 1'b0;
        write_freq(0, 28'h0123457, "R2");
        write_freq(1, 28'h0A00001, "R2");
        repeat (10) step("R2");
        ctl_clk_off = 1'b1;
        step("R3");
        held = amp_out;
        for (int k = 0; k < 20; k++) begin
            if (k == 3) begin freq_we = 1'b1; freq_idx = 1'b0; freq_data = 28'h0F00000; end
            if (k == 4) freq_we = 1'b0;
            if (k == 6) begin phase_we = 1'b1; phase_idx = 1'b1; phase_data = 12'h300; end
            if (k == 7) phase_we = 1'b0;
            if (k == 9) phase_sel = 1'b1;
            if (k == 12) freq_sel = 1'b1;
            step("R4");
            check("R3 frozen amp", int'(amp_out), int'(held));
        end
        ctl_clk_off = 1'b0;
        repeat (8) step("R4");

        // R6/R7: software power-down alone, together with freeze, pin ignored
        ctl_dac_off = 1'b1;
        repeat (3) step("R7");
        ctl_clk_off = 1'b1;
        repeat (3) step("R6");
        ctl_dac_off = 1'b0;
        repeat (2) step("R6");
        ctl_clk_off = 1'b0;
        sleep_pin = 1'b1;
        repeat (3) step("R6 pin ignored");
        sleep_pin = 1'b0;
        repeat (3) step("R6");

        // R5: pin path with a stationary datapath
        freq_sel = 1'b0;
        phase_sel = 1'b0;
        write_freq(0, '0, "R5");
        repeat (4) step("R5");
        pin_sw_sel = 1'b1;
        ctl_clk_off = 1'b1;
        ctl_dac_off = 1'b1;
        repeat (3) step("R6 ctl ignored");
        ctl_clk_off = 1'b0;
        ctl_dac_off = 1'b0;
        repeat (3) step("R5");
        sleep_pin = 1'b1;
        #1;
        check("R5 immediate enable", int'(dac_enable), 0);
        check("R5 immediate amp", int'(amp_out), MID);
        step("R5");
        sleep_pin = 1'b0;
        #1;
        check("R5 no instant release", int'(dac_enable), 0);
        @(negedge clk);
        #1;
        check("R5 after one fall", int'(dac_enable), 0);
        @(negedge clk);
        #1;
        check("R5 after two falls", int'(dac_enable), 1);
        check("R5 restored amp", int'(amp_out), int'(m_amp));
        step("R5");
        pin_sw_sel = 1'b0;

        // R2: constrained random mix of writes, selects, sleeps and mode
        for (int k = 0; k < 3000; k++) begin
            freq_we     = ($urandom_range(3) == 0);
            freq_idx    = 1'($urandom_range(1));
            freq_data   = ($urandom_range(1) == 0) ? ACC_W'($urandom) : ACC_W'($urandom_range(1 << 20));
            phase_we    = ($urandom_range(3) == 0);
            phase_idx   = 1'($urandom_range(1));
            phase_data  = PH_W'($urandom);
            freq_sel    = 1'($urandom_range(1));
            phase_sel   = 1'($urandom_range(1));
            wave_tri    = ($urandom_range(7) == 0) ? ~wave_tri : wave_tri;
            ctl_clk_off = ($urandom_range(7) == 0);
            ctl_dac_off = ($urandom_range(7) == 0);
            pin_sw_sel  = ($urandom_range(7) == 0);
            step("R2");
        end
        freq_we = 1'b0; phase_we = 1'b0;
        ctl_clk_off = 1'b0; ctl_dac_off = 1'b0; pin_sw_sel = 1'b0;

        // R9: full triangle period, one step of phase per clock
        wave_tri = 1'b1; freq_sel = 1'b0; phase_sel = 1'b0;
        write_phase(0, 0, "R9");
        write_freq(0, ACC_W'(1 << 16), "R9");
        guard = 0;
        while (amp_out != 10'd100 && guard < 6000) begin
            step("R9");
            guard++;
        end
        check("R9 sweep start found", (guard < 6000) ? 1 : 0, 1);
        zero_runs = 0; peak_runs = 0; lo = 1023; hi = 0; prev = 100;
        for (int k = 0; k < 4096; k++) begin
            step("R9");
            if (amp_out == 0 && prev != 0) zero_runs++;
            if (amp_out == 1023 && prev != 1023) peak_runs++;
            if (int'(amp_out) < lo) lo = int'(amp_out);
            if (int'(amp_out) > hi) hi = int'(amp_out);
            prev = int'(amp_out);
        end
        check("R9 zero visits", zero_runs, 1);
        check("R9 peak visits", peak_runs, 1);
        check("R9 minimum", lo, 0);
        check("R9 maximum", hi, 1023);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule